// File: doc/BRIEF.md
# Multidrop Wake-Up Serial Receiver

This block is the receive half of one asynchronous serial channel. It samples an incoming line with a 16X oversampling tick, confirms start bits, assembles 8-bit characters sent least significant bit first, and places each character in a 16-entry queue. Every character carries three status flags that travel beside it through the queue.

A ninth bit may follow the data bits. In normal mode, with parity enabled, that bit is checked against even or odd parity. In multidrop mode it marks the character as an address or as data, and it is stored in the status slot that the parity error uses in normal mode. Software decides what to do with address characters.

The CPU side sees the oldest character and its status at all times, and removes both with one pop. Ready, full and fill-threshold indications are combinational on the queue occupancy. Framing, break and overrun detection keep running while the receiver is disabled. Only the loading of the queue stops.

Top module: `mdrop_rx`

## Requirements
- R1: After reset, rx_ready, fifo_full, fill_hit and overrun are all 0.
- R2: A start bit is accepted only if the line is still low at the eighth oversampling tick after the first low sample. A shorter low pulse loads nothing.
- R3: The data bits are sampled every 16 ticks after the start sample, least significant bit first. Characters are read back in the order they arrived, with rd_data showing the oldest entry.
- R4: With par_en=1 and md_mode=0, rd_stat[0] is 1 when the data bits and the ninth bit together hold an odd number of ones and par_odd=0, or an even number of ones and par_odd=1. Otherwise it is 0.
- R5: With md_mode=1, a ninth bit is always received, no parity check is made, and rd_stat[0] equals the received ninth bit whatever par_odd is.
- R6: A stop bit sampled as 0 sets rd_stat[1] (framing error) for that character, and fe_evt pulses for one cycle.
- R7: If the data bits, any ninth bit and the stop bit are all 0, rd_stat[2] (break) and rd_stat[1] are set and brk_evt pulses. The receiver does not look for a new start bit until the line has returned high, so a held break yields one entry only.
- R8: While rx_en=0, completed characters are not loaded, but fe_evt, brk_evt and overrun are still produced.
- R9: A character that completes while the queue holds 16 entries is dropped, the 16 stored entries are kept, and overrun rises and stays 1 until ovr_clr is asserted.
- R10: rx_ready is 1 exactly when the queue is not empty. A pop on an empty queue has no effect.
- R11: fifo_full is 1 exactly when the queue holds 16 entries.
- R12: fill_hit is 1 when the occupancy is at least 1, 8, 12 or 16 for fill_sel 0, 1, 2 or 3 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | 16X oversampling enable, one cycle per tick |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Allows completed characters into the queue |
| md_mode | input | 1 | 1 selects multidrop (address/data ninth bit) |
| par_en | input | 1 | 1 enables the parity bit in normal mode |
| par_odd | input | 1 | 1 selects odd parity, 0 even |
| fill_sel | input | 2 | Fill-threshold select |
| rd_pop | input | 1 | Removes the oldest character and its status |
| ovr_clr | input | 1 | Clears the sticky overrun flag |
| rd_data | output | 8 | Oldest character |
| rd_stat | output | 3 | Oldest status: [2] break, [1] framing, [0] parity error or address flag |
| rx_ready | output | 1 | Queue not empty |
| fifo_full | output | 1 | Queue holds 16 entries |
| fill_hit | output | 1 | Occupancy at or above the selected threshold |
| overrun | output | 1 | Sticky: a character was lost to a full queue |
| fe_evt | output | 1 | One-cycle pulse on a framing error |
| brk_evt | output | 1 | One-cycle pulse on a break character |

## Verification
The hardest state to reach is a completed character arriving at a queue that is exactly full. The bench only gets there by streaming sixteen framed characters while checking every threshold setting at each occupancy on the way. It then sends a seventeenth character with the receiver enabled, and an eighteenth with it disabled. Draining all sixteen entries afterwards shows that neither extra character replaced a stored one. The held break is driven low for several bit times past its stop bit, to show that exactly one entry results.

// File: rtl/mdrop_rx_pkg.sv
// Shared types for the multidrop receiver.
// Assumes nothing beyond a packed three-flag status layout.
package mdrop_rx_pkg;
    typedef struct packed {
        logic brk;      // all-zero character with a zero stop bit
        logic fe;       // stop bit sampled low
        logic pe_ad;    // parity error, or the address flag in multidrop mode
    } rx_stat_t;

    localparam int STAT_W = 3;
endpackage

// File: rtl/mdrop_rx_sampler.sv
// Oversampling deserializer. Confirms the start bit at mid-bit, samples each
// following bit every OS ticks, and pulses done for one cycle with the data,
// the optional ninth bit and the stop bit.
// Assumes: rxd is asynchronous (a two-flop synchronizer is inside), os_tick
// is a single-cycle enable, and OS is even.
module mdrop_rx_sampler #(
    parameter int DATA_W = 8,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              ninth_en,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              ninth,
    output logic              stop_bit
);
    localparam int CW   = $clog2(OS);
    localparam int HALF = OS / 2;
    localparam int SW   = DATA_W + 2;
    localparam int IW   = $clog2(DATA_W + 3);

    typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_WAITH} st_t;

    st_t           state;
    logic [1:0]    sync_q;
    logic          rxd_s;
    logic [CW-1:0] cnt;
    logic [IW-1:0] idx;
    logic [IW-1:0] last_idx;
    logic [SW-1:0] sh;
    logic [SW-1:0] sh_n;

    assign rxd_s    = sync_q[1];
    assign sh_n     = {rxd_s, sh[SW-1:1]};
    assign last_idx = ninth_en ? IW'(DATA_W + 1) : IW'(DATA_W);

    // Bring the line into the clock domain, idle high from reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rxd};
    end

    // Frame sequencer: start check, bit sampling, wait for line release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            cnt      <= '0;
            idx      <= '0;
            sh       <= '0;
            done     <= 1'b0;
            data     <= '0;
            ninth    <= 1'b0;
            stop_bit <= 1'b1;
        end else begin
            done <= 1'b0;
            if (os_tick) begin
                unique case (state)
                    S_IDLE: if (!rxd_s) begin
                        state <= S_START;
                        cnt   <= '0;
                    end
                    S_START: if (cnt == CW'(HALF - 1)) begin
                        state <= rxd_s ? S_IDLE : S_BITS;
                        cnt   <= '0;
                        idx   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    S_BITS: if (cnt == CW'(OS - 1)) begin
                        cnt <= '0;
                        sh  <= sh_n;
                        idx <= idx + 1'b1;
                        if (idx == last_idx) begin
                            done     <= 1'b1;
                            stop_bit <= rxd_s;
                            if (ninth_en) begin
                                data  <= sh_n[DATA_W-1:0];
                                ninth <= sh_n[DATA_W];
                            end else begin
                                data  <= sh_n[DATA_W:1];
                                ninth <= 1'b0;
                            end
                            state <= rxd_s ? S_IDLE : S_WAITH;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                    S_WAITH: if (rxd_s) state <= S_IDLE;
                    default: state <= S_IDLE;
                endcase
            end
        end
    end

    // R3: each completed character is reported by exactly one pulse.
    p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

// File: rtl/mdrop_rx_fifo.sv
// Character queue with first-word fall-through read. A pop on an empty
// queue is ignored here.
// Assumes: DEPTH is a power of two, and the writer never pushes when full.
module mdrop_rx_fifo #(
    parameter int W     = 11,
    parameter int DEPTH = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr,
    input  logic [W-1:0]               wdata,
    input  logic                       rd,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp;
    logic [PW-1:0] rp;
    logic          rd_ok;

    assign rd_ok = rd && (count != '0);
    assign head  = mem[rp];

    // Storage write; no reset is needed on the payload.
    always_ff @(posedge clk) begin
        if (wr) mem[wp] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (wr)    wp <= wp + 1'b1;
            if (rd_ok) rp <= rp + 1'b1;
            count <= count + CW'(wr) - CW'(rd_ok);
        end
    end

    // R11: occupancy never passes the depth.
    p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R9: the writer has already dropped the characters that would overflow.
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && count == CW'(DEPTH)));
endmodule

// File: rtl/mdrop_rx.sv
// Multidrop-capable receive channel: the sampler feeds status generation
// (parity or address flag, framing, break), which feeds the queue. Queue
// flags and the fill threshold are decoded from the occupancy.
// Assumes: the ninth bit is present when md_mode or par_en is set, with one
// stop bit, and DEPTH is a power of two of at least 4.
module mdrop_rx
    import mdrop_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 16,
    parameter int OS     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              rx_en,
    input  logic              md_mode,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic [1:0]        fill_sel,
    input  logic              rd_pop,
    input  logic              ovr_clr,
    output logic [DATA_W-1:0] rd_data,
    output logic [2:0]        rd_stat,
    output logic              rx_ready,
    output logic              fifo_full,
    output logic              fill_hit,
    output logic              overrun,
    output logic              fe_evt,
    output logic              brk_evt
);
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int FW   = DATA_W + STAT_W;
    localparam int THR1 = 1;
    localparam int THR2 = DEPTH / 2;
    localparam int THR3 = (3 * DEPTH) / 4;
    localparam int THR4 = DEPTH;

    logic              done;
    logic [DATA_W-1:0] ch;
    logic              ninth;
    logic              stop_bit;
    rx_stat_t          st;
    rx_stat_t          head_st;
    logic [FW-1:0]     head;
    logic [CW-1:0]     count;
    logic              fifo_wr;
    logic [CW-1:0]     thr;

    mdrop_rx_sampler #(.DATA_W(DATA_W), .OS(OS)) u_smp (
        .clk      (clk),
        .rst_n    (rst_n),
        .os_tick  (os_tick),
        .rxd      (rxd),
        .ninth_en (md_mode | par_en),
        .done     (done),
        .data     (ch),
        .ninth    (ninth),
        .stop_bit (stop_bit)
    );

    // Build the per-character status; multidrop reuses the parity slot.
    always_comb begin
        st.fe    = !stop_bit;
        st.brk   = !stop_bit && (ch == '0) && !ninth;
        if (md_mode) st.pe_ad = ninth;
        else         st.pe_ad = par_en && ((^ch) ^ ninth ^ par_odd);
    end

    assign fe_evt  = done && st.fe;
    assign brk_evt = done && st.brk;
    assign fifo_wr = done && rx_en && !fifo_full;

    mdrop_rx_fifo #(.W(FW), .DEPTH(DEPTH)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (fifo_wr),
        .wdata ({st, ch}),
        .rd    (rd_pop),
        .head  (head),
        .count (count)
    );

    assign head_st   = head[FW-1:DATA_W];
    assign rd_data   = head[DATA_W-1:0];
    assign rd_stat   = head_st;
    assign rx_ready  = (count != '0);
    assign fifo_full = (count == CW'(DEPTH));

    // Pick the fill threshold from the select field.
    always_comb begin
        unique case (fill_sel)
            2'd0:    thr = CW'(THR1);
            2'd1:    thr = CW'(THR2);
            2'd2:    thr = CW'(THR3);
            default: thr = CW'(THR4);
        endcase
    end
    assign fill_hit = (count >= thr);

    // Sticky overrun: set on a completion into a full queue, even if disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                overrun <= 1'b0;
        else if (done && fifo_full) overrun <= 1'b1;
        else if (ovr_clr)          overrun <= 1'b0;
    end

    // R9: overrun holds until it is cleared.
    p_overrun_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overrun && !ovr_clr |=> overrun);
    // R8: the queue only fills while the receiver is enabled.
    p_load_enabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(rx_en));
    // R7: a break is always also a framing error.
    p_break_is_fe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        brk_evt |-> fe_evt);
    // R10: ready rises only after a sampler completion.
    p_ready_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ready) |-> $past(done));
endmodule

// File: tb/sim_mdrop_rx.sv
module sim_mdrop_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b1;
    logic       rxd = 1'b1;
    logic       rx_en = 1'b1;
    logic       md_mode = 1'b0;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic [1:0] fill_sel = 2'd0;
    logic       rd_pop = 1'b0;
    logic       ovr_clr = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rd_stat;
    logic       rx_ready, fifo_full, fill_hit, overrun, fe_evt, brk_evt;

    int checks = 0;
    int errors = 0;
    int fe_cnt = 0;
    int brk_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mdrop_rx u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd), .rx_en(rx_en),
        .md_mode(md_mode), .par_en(par_en), .par_odd(par_odd),
        .fill_sel(fill_sel), .rd_pop(rd_pop), .ovr_clr(ovr_clr),
        .rd_data(rd_data), .rd_stat(rd_stat), .rx_ready(rx_ready),
        .fifo_full(fifo_full), .fill_hit(fill_hit), .overrun(overrun),
        .fe_evt(fe_evt), .brk_evt(brk_evt)
    );

    // Event counters for the pulse outputs.
    always @(posedge clk) begin
        if (fe_evt)  fe_cnt  <= fe_cnt + 1;
        if (brk_evt) brk_cnt <= brk_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bit_out(input logic v);
        rxd = v;
        repeat (16) @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input logic has9, input logic b9,
                        input logic stop);
        bit_out(1'b0);
        for (int i = 0; i < 8; i++) bit_out(d[i]);
        if (has9) bit_out(b9);
        bit_out(stop);
        rxd = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        @(negedge clk);
    endtask

    function automatic int thr_of(input int sel);
        case (sel)
            0: return 1;
            1: return 8;
            2: return 12;
            default: return 16;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int fe0, brk0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rx_ready", rx_ready, 0);
        check("R1 fifo_full", fifo_full, 0);
        check("R1 fill_hit", fill_hit, 0);
        check("R1 overrun", overrun, 0);

        // R2: a low glitch shorter than half a bit is rejected
        rxd = 1'b0;
        repeat (4) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R2 glitch ignored", rx_ready, 0);

        // R3: plain character, LSB first
        send(8'hA5, 1'b0, 1'b0, 1'b1);
        check("R3 ready", rx_ready, 1);
        check("R3 data", rd_data, 8'hA5);
        check("R3 status", rd_stat, 0);
        pop();
        check("R10 empty after pop", rx_ready, 0);
        // R10: pop on an empty queue has no effect
        pop();
        send(8'h3C, 1'b0, 1'b0, 1'b1);
        check("R10 pop-empty ignored count", rx_ready, 1);
        check("R10 pop-empty ignored data", rd_data, 8'h3C);
        pop();

        // R4: parity sweep, even and odd, correct and flipped
        par_en = 1'b1;
        for (int k = 0; k < 8; k++) begin
            for (int od = 0; od < 2; od++) begin
                for (int fl = 0; fl < 2; fl++) begin
                    logic [7:0] d;
                    logic pok;
                    d = 8'((k * 37 + 5) & 255);
                    pok = (^d) ^ od[0];
                    par_odd = od[0];
                    send(d, 1'b1, pok ^ fl[0], 1'b1);
                    check("R4 data", rd_data, d);
                    check("R4 parity flag", rd_stat[0], fl);
                    pop();
                end
            end
        end
        par_en = 1'b0;

        // R5: multidrop flag carried in the parity slot
        md_mode = 1'b1;
        for (int b = 0; b < 2; b++) begin
            for (int od = 0; od < 2; od++) begin
                par_odd = od[0];
                send(8'h81 + 8'(b), 1'b1, b[0], 1'b1);
                check("R5 data", rd_data, 8'h81 + b);
                check("R5 addr flag", rd_stat[0], b);
                pop();
            end
        end
        md_mode = 1'b0;

        // R6: framing error
        fe0 = fe_cnt;
        send(8'h5A, 1'b0, 1'b0, 1'b0);
        check("R6 fe status", rd_stat, 3'b010);
        check("R6 fe_evt", fe_cnt - fe0, 1);
        pop();
        check("R6 single entry", rx_ready, 0);

        // R7: held break gives one entry only
        fe0 = fe_cnt; brk0 = brk_cnt;
        rxd = 1'b0;
        repeat (16 * 12) @(negedge clk);
        rxd = 1'b1;
        repeat (40) @(negedge clk);
        check("R7 break status", rd_stat, 3'b110);
        check("R7 break data", rd_data, 0);
        check("R7 brk_evt", brk_cnt - brk0, 1);
        pop();
        check("R7 one entry", rx_ready, 0);

        // R8: disabled receiver loads nothing, error detection continues
        rx_en = 1'b0;
        send(8'h55, 1'b0, 1'b0, 1'b1);
        check("R8 not loaded", rx_ready, 0);
        fe0 = fe_cnt; brk0 = brk_cnt;
        send(8'h0F, 1'b0, 1'b0, 1'b0);
        check("R8 fe while disabled", fe_cnt - fe0, 1);
        check("R8 not loaded fe", rx_ready, 0);
        send(8'h00, 1'b0, 1'b0, 1'b0);
        check("R8 break while disabled", brk_cnt - brk0, 1);
        check("R8 not loaded brk", rx_ready, 0);
        rx_en = 1'b1;

        // R11 R12: fill sweep at every occupancy and threshold
        for (int n = 1; n <= 16; n++) begin
            send(8'(8'h10 + n - 1), 1'b0, 1'b0, 1'b1);
            for (int s = 0; s < 4; s++) begin
                fill_sel = 2'(s);
                @(negedge clk);
                check("R12 fill_hit", fill_hit, (n >= thr_of(s)) ? 1 : 0);
            end
            check("R11 fifo_full", fifo_full, (n == 16) ? 1 : 0);
        end

        // R9: overrun enabled, then disabled (R8)
        send(8'hEE, 1'b0, 1'b0, 1'b1);
        check("R9 overrun set", overrun, 1);
        repeat (5) @(negedge clk);
        check("R9 overrun sticky", overrun, 1);
        ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
        check("R9 overrun cleared", overrun, 0);
        rx_en = 1'b0;
        send(8'hDD, 1'b0, 1'b0, 1'b1);
        check("R8 overrun while disabled", overrun, 1);
        rx_en = 1'b1;
        for (int n = 0; n < 16; n++) begin
            check("R9 kept entry", rd_data, 8'h10 + n);
            pop();
        end
        check("R9 dropped extra", rx_ready, 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule